// File: doc/BRIEF.md
# Conditional Move Execution Unit

This unit executes the two-byte conditional move in a flag-based processor core. It receives one instruction at a time with a valid/ready handshake: the two opcode bytes, the ModR/M byte, the status flags, the mode and override bits that set the operand width, and the destination and register-source values. The register file reads those values using the index outputs, which are decoded straight from the ModR/M byte.

The unit first checks that the opcode belongs to the conditional move group. It then evaluates the 4-bit condition against the flags, using the same encoding as conditional branches. When the condition holds, it writes the source into the destination register. A register source finishes on the cycle after it is accepted.

A memory source always raises a read request, whatever the condition says. The unit keeps the condition result until the memory response arrives. A fault on that read is reported and blocks the write, even when the condition is false. Completion is signalled by a one-cycle done pulse. The unit has no path for writing flags, so no flag changes.

Top module: `cmov_unit`

## Requirements
- R1: An instruction is a conditional move only when the first opcode byte is 0x0F and the upper nibble of the second byte is 0x4. Any other accepted instruction completes with a done pulse one cycle after acceptance, with no write, no memory request and no fault.
- R2: The condition code is bits [3:0] of the second byte, and flags_i carries CF in bit 0, PF in bit 1, ZF in bit 2, SF in bit 3 and OF in bit 4. Bits [3:1] of the condition code select a base test: 0 = OF, 1 = CF, 2 = ZF, 3 = CF or ZF, 4 = SF, 5 = PF, 6 = SF differs from OF, 7 = ZF or (SF differs from OF). Bit 0 of the condition code inverts the result.
- R3: When the condition holds, wr_en_o is asserted together with done_o, and wr_idx_o equals ModR/M bits [5:3]. When the condition fails, wr_en_o stays low. dst_idx_o shows ModR/M bits [5:3] and src_idx_o shows ModR/M bits [2:0], both combinationally.
- R4: ModR/M bits [7:6] = 11 select a register source. Such an instruction raises no memory request, and done_o goes high in the cycle after acceptance.
- R5: Any other mod value selects a memory source. mem_req_o rises in the cycle after acceptance and stays high until mem_rsp_valid_i. This happens whether the condition is true or false.
- R6: If mem_fault_i is high with the response, fault_o pulses with done_o and no write occurs, whether the condition is true or false.
- R7: The operand is 32 bits wide when mode32_i XOR opsz_ovr_i is 1, and 16 bits otherwise. A 32-bit move writes the whole source. A 16-bit move writes the low half of the source and keeps the upper 16 bits of the destination.
- R8: req_ready_o is low while a memory read is outstanding. done_o is a single-cycle pulse for each instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Instruction valid |
| req_ready_o | output | 1 | Unit can accept an instruction |
| op0_i | input | 8 | First opcode byte |
| op1_i | input | 8 | Second opcode byte |
| modrm_i | input | 8 | ModR/M byte |
| flags_i | input | 5 | Status flags {OF,SF,ZF,PF,CF} |
| mode32_i | input | 1 | Current mode default width is 32 bits |
| opsz_ovr_i | input | 1 | Operand-size override present |
| dst_idx_o | output | 3 | Destination register read index |
| src_idx_o | output | 3 | Source register read index |
| dst_val_i | input | 32 | Current destination value |
| src_val_i | input | 32 | Register source value |
| mem_req_o | output | 1 | Memory read request |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_data_i | input | 32 | Memory read data |
| mem_fault_i | input | 1 | Memory read faulted |
| wr_en_o | output | 1 | Register write enable |
| wr_idx_o | output | 3 | Register write index |
| wr_data_o | output | 32 | Register write data |
| fault_o | output | 1 | Fault raised by this instruction |
| done_o | output | 1 | Instruction complete pulse |

## Verification
All sixteen condition codes are run against flag patterns that separate each base test from its inverse, and against patterns where SF and OF agree or differ. A design with a wrong table entry or a lost inversion bit would write when it should not. Memory sources are run with false conditions and with faults. A unit that skips the read on a false condition, or that writes despite a fault, is caught by the request check and by the scoreboard. Every mode and override combination is covered; a 16-bit move that clears the upper half instead of keeping it shows up as a data mismatch. Opcodes that differ from the conditional move group by one nibble must complete with no side effect.

// File: rtl/cmov_pkg.sv
package cmov_pkg;
  localparam int FLAG_W = 5;
  localparam int CF_B = 0;
  localparam int PF_B = 1;
  localparam int ZF_B = 2;
  localparam int SF_B = 3;
  localparam int OF_B = 4;

  typedef enum logic [0:0] {ST_IDLE, ST_MEM} state_e;

  typedef struct packed {
    logic       valid;
    logic [3:0] cc;
    logic [2:0] dst_idx;
    logic [2:0] src_idx;
    logic       mem_src;
  } dec_t;
endpackage

// File: rtl/cmov_decode.sv
module cmov_decode
  import cmov_pkg::*;
#(
  parameter logic [7:0] ESC_BYTE = 8'h0F,
  parameter logic [3:0] GRP_NIB  = 4'h4
) (
  input  logic [7:0] op0_i,
  input  logic [7:0] op1_i,
  input  logic [7:0] modrm_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o.valid   = (op0_i == ESC_BYTE) && (op1_i[7:4] == GRP_NIB);
    dec_o.cc      = op1_i[3:0];
    dec_o.dst_idx = modrm_i[5:3];
    dec_o.src_idx = modrm_i[2:0];
    dec_o.mem_src = (modrm_i[7:6] != 2'b11);
  end
endmodule

// File: rtl/cmov_cond_eval.sv
module cmov_cond_eval
  import cmov_pkg::*;
(
  input  logic [3:0]        cc_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              hit_o
);
  logic of_f, sf_f, zf_f, pf_f, cf_f, lt_f, base;

  assign of_f = flags_i[OF_B];
  assign sf_f = flags_i[SF_B];
  assign zf_f = flags_i[ZF_B];
  assign pf_f = flags_i[PF_B];
  assign cf_f = flags_i[CF_B];
  assign lt_f = sf_f ^ of_f;

  always_comb begin
    unique case (cc_i[3:1])
      3'd0: base = of_f;
      3'd1: base = cf_f;
      3'd2: base = zf_f;
      3'd3: base = cf_f | zf_f;
      3'd4: base = sf_f;
      3'd5: base = pf_f;
      3'd6: base = lt_f;
      default: base = zf_f | lt_f;
    endcase
  end

  // low bit flips the sense of the base test
  assign hit_o = base ^ cc_i[0];
endmodule

// File: rtl/cmov_merge.sv
module cmov_merge #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic              wide_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int UPPER_W = DATA_W - HALF_W;

  generate
    if (UPPER_W > 0) begin : g_split
      assign data_o = wide_i ? src_i : {dst_i[DATA_W-1:HALF_W], src_i[HALF_W-1:0]};
    end else begin : g_flat
      assign data_o = src_i;
    end
  endgenerate
endmodule

// File: rtl/cmov_unit.sv
module cmov_unit
  import cmov_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [7:0]        op0_i,
  input  logic [7:0]        op1_i,
  input  logic [7:0]        modrm_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              mode32_i,
  input  logic              opsz_ovr_i,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic [IDX_W-1:0]  src_idx_o,
  input  logic [DATA_W-1:0] dst_val_i,
  input  logic [DATA_W-1:0] src_val_i,
  output logic              mem_req_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  input  logic              mem_fault_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              fault_o,
  output logic              done_o
);
  state_e            state_q;
  dec_t              dec;
  logic              hit, accept, rsp_take, wide_now;
  logic              cond_q, wide_q;
  logic [DATA_W-1:0] dst_q;
  logic [IDX_W-1:0]  idx_q;
  logic              m_wide;
  logic [DATA_W-1:0] m_dst, m_src, m_data;
  logic              wr_en_q, fault_q, done_q;
  logic [IDX_W-1:0]  wr_idx_q;
  logic [DATA_W-1:0] wr_data_q;

  cmov_decode u_dec (
    .op0_i  (op0_i),
    .op1_i  (op1_i),
    .modrm_i(modrm_i),
    .dec_o  (dec)
  );

  cmov_cond_eval u_cond (
    .cc_i   (dec.cc),
    .flags_i(flags_i),
    .hit_o  (hit)
  );

  assign wide_now = mode32_i ^ opsz_ovr_i;
  assign m_wide   = (state_q == ST_MEM) ? wide_q         : wide_now;
  assign m_dst    = (state_q == ST_MEM) ? dst_q          : dst_val_i;
  assign m_src    = (state_q == ST_MEM) ? mem_rsp_data_i : src_val_i;

  cmov_merge #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_merge (
    .wide_i(m_wide),
    .dst_i (m_dst),
    .src_i (m_src),
    .data_o(m_data)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign rsp_take    = (state_q == ST_MEM) && mem_rsp_valid_i;
  assign dst_idx_o   = dec.dst_idx;
  assign src_idx_o   = dec.src_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cond_q    <= 1'b0;
      wide_q    <= 1'b0;
      dst_q     <= '0;
      idx_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
      fault_q   <= 1'b0;
      done_q    <= 1'b0;
    end else if (accept && dec.valid && dec.mem_src) begin
      // memory source: read is issued whatever the condition
      state_q <= ST_MEM;
      cond_q  <= hit;
      wide_q  <= wide_now;
      dst_q   <= dst_val_i;
      idx_q   <= dec.dst_idx;
      wr_en_q <= 1'b0;
      fault_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (accept) begin
      wr_en_q   <= dec.valid && hit;
      wr_idx_q  <= dec.dst_idx;
      wr_data_q <= m_data;
      fault_q   <= 1'b0;
      done_q    <= 1'b1;
    end else if (rsp_take) begin
      state_q   <= ST_IDLE;
      wr_en_q   <= cond_q && !mem_fault_i;
      wr_idx_q  <= idx_q;
      wr_data_q <= m_data;
      fault_q   <= mem_fault_i;
      done_q    <= 1'b1;
    end else begin
      wr_en_q <= 1'b0;
      fault_q <= 1'b0;
      done_q  <= 1'b0;
    end
  end

  assign mem_req_o = (state_q == ST_MEM);
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
  assign fault_o   = fault_q;
  assign done_o    = done_q;

  // R1
  foreign_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !(op0_i == 8'h0F && op1_i[7:4] == 4'h4))
      |=> (done_o && !wr_en_o && !mem_req_o && !fault_o));
  // R3
  write_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> done_o);
  // R4
  reg_src_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && modrm_i[7:6] == 2'b11) |=> (done_o && !mem_req_o));
  // R5
  mem_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && op0_i == 8'h0F && op1_i[7:4] == 4'h4
     && modrm_i[7:6] != 2'b11) |=> mem_req_o);
  // R5
  mem_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_valid_i) |=> mem_req_o);
  // R6
  fault_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!wr_en_o && done_o));
  // R8
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !mem_req_o && !$past(req_valid_i)) |=> !done_o);
endmodule

// File: tb/cmov_unit_test.sv
module cmov_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  op0 = '0, op1 = '0, modrm = '0;
  logic [4:0]  flags = '0;
  logic        mode32 = 1'b1, ovr = 1'b0;
  logic [2:0]  dst_idx, src_idx;
  logic [31:0] dst_val = '0, src_val = '0;
  logic        mem_req;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        rsp_fault = 1'b0;
  logic        wr_en, fault, done;
  logic [2:0]  wr_idx;
  logic [31:0] wr_data;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        wr;
    logic [2:0]  idx;
    logic [31:0] data;
    logic        flt;
    string       req;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  cmov_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .op0_i(op0), .op1_i(op1), .modrm_i(modrm), .flags_i(flags),
    .mode32_i(mode32), .opsz_ovr_i(ovr), .dst_idx_o(dst_idx), .src_idx_o(src_idx),
    .dst_val_i(dst_val), .src_val_i(src_val), .mem_req_o(mem_req),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data), .mem_fault_i(rsp_fault),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .fault_o(fault), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // flags: [0]=CF [1]=PF [2]=ZF [3]=SF [4]=OF
  function automatic logic cond_ref(input logic [3:0] cc, input logic [4:0] f);
    logic cf, pf, zf, sf, of_;
    cf = f[0]; pf = f[1]; zf = f[2]; sf = f[3]; of_ = f[4];
    case (cc)
      4'd0:  return of_;
      4'd1:  return !of_;
      4'd2:  return cf;
      4'd3:  return !cf;
      4'd4:  return zf;
      4'd5:  return !zf;
      4'd6:  return cf || zf;
      4'd7:  return !(cf || zf);
      4'd8:  return sf;
      4'd9:  return !sf;
      4'd10: return pf;
      4'd11: return !pf;
      4'd12: return sf != of_;
      4'd13: return sf == of_;
      4'd14: return zf || (sf != of_);
      default: return !(zf || (sf != of_));
    endcase
  endfunction

  task automatic run_op(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] mr,
                        input logic [4:0] fl, input logic m32, input logic ov,
                        input logic [31:0] dv, input logic [31:0] sv, input logic [31:0] md,
                        input logic flt, input int lat, input string req);
    exp_t e;
    logic is_op, is_mem, wide;
    logic [31:0] srcv;
    is_op  = (b0 == 8'h0F) && (b1[7:4] == 4'h4);
    is_mem = (mr[7:6] != 2'b11);
    wide   = m32 ^ ov;
    srcv   = is_mem ? md : sv;
    e.wr   = is_op && cond_ref(b1[3:0], fl) && !(is_mem && flt);
    e.idx  = mr[5:3];
    e.data = wide ? srcv : {dv[31:16], srcv[15:0]};
    e.flt  = is_op && is_mem && flt;
    e.req  = req;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    q.push_back(e);
    op0 = b0; op1 = b1; modrm = mr; flags = fl; mode32 = m32; ovr = ov;
    dst_val = dv; src_val = sv; req_valid = 1'b1;
    #1;
    check(dst_idx == mr[5:3] && src_idx == mr[2:0], "R3", "read index",
          {26'd0, dst_idx, src_idx}, {26'd0, mr[5:3], mr[2:0]});
    @(negedge clk);
    req_valid = 1'b0;
    if (is_op && is_mem) begin
      check(mem_req == 1'b1, "R5", "mem_req after accept", {31'd0, mem_req}, 32'd1);
      check(req_ready == 1'b0, "R8", "ready while busy", {31'd0, req_ready}, 32'd0);
      repeat (lat) begin
        @(negedge clk);
        check(mem_req == 1'b1, "R5", "mem_req held", {31'd0, mem_req}, 32'd1);
      end
      rsp_valid = 1'b1; rsp_data = md; rsp_fault = flt;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_fault = 1'b0;
      check(done == 1'b1 && mem_req == 1'b0, "R5", "done after response",
            {30'd0, done, mem_req}, 32'd2);
    end else begin
      check(mem_req == 1'b0 && done == 1'b1, is_op ? "R4" : "R1", "done, no mem_req",
            {30'd0, done, mem_req}, 32'd2);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en && !done) check(1'b0, "R3", "write without done", 32'd1, 32'd0);
      if (done) begin
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(wr_en == e.wr, e.req, "wr_en", {31'd0, wr_en}, {31'd0, e.wr});
          check(fault == e.flt, e.flt ? "R6" : e.req, "fault", {31'd0, fault}, {31'd0, e.flt});
          if (e.wr) begin
            check(wr_idx == e.idx, "R3", "wr_idx", {29'd0, wr_idx}, {29'd0, e.idx});
            check(wr_data == e.data, e.req, "wr_data", wr_data, e.data);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] pats[6];
    pats[0] = 5'b00000; pats[1] = 5'b11111; pats[2] = 5'b10101;
    pats[3] = 5'b01010; pats[4] = 5'b10000; pats[5] = 5'b01000;
    repeat (3) @(negedge clk);
    check(req_ready && !done && !wr_en && !mem_req && !fault, "R8", "reset state",
          {27'd0, req_ready, done, wr_en, mem_req, fault}, 32'h10);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: full condition table, register source
    for (int cc = 0; cc < 16; cc++) begin
      for (int p = 0; p < 6; p++) begin
        run_op(8'h0F, {4'h4, 4'(cc)}, {2'b11, 3'(cc), 3'(p)}, pats[p], 1'b1, 1'b0,
               32'hAAAA_5555 + 32'(cc), 32'h1234_0000 + 32'(p * 16 + cc), 32'h0, 1'b0, 0, "R2");
      end
    end
    // R7: width selection, condition always true (cc=1, OF=0)
    run_op(8'h0F, 8'h41, 8'hCA, 5'b00000, 1'b1, 1'b0, 32'hDEAD_BEEF, 32'h0102_0304, 0, 0, 0, "R7");
    run_op(8'h0F, 8'h41, 8'hCA, 5'b00000, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'h0102_0304, 0, 0, 0, "R7");
    run_op(8'h0F, 8'h41, 8'hCA, 5'b00000, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'h0102_0304, 0, 0, 0, "R7");
    run_op(8'h0F, 8'h41, 8'hCA, 5'b00000, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0102_0304, 0, 0, 0, "R7");
    // R3: condition false leaves destination alone
    run_op(8'h0F, 8'h40, 8'hD9, 5'b00000, 1'b1, 1'b0, 32'h1, 32'h2, 0, 0, 0, "R3");
    // R5: memory source, condition true and false, various latencies and mods
    run_op(8'h0F, 8'h44, 8'h06, 5'b00100, 1'b1, 1'b0, 32'h0, 32'h0, 32'hCAFE_F00D, 0, 0, "R5");
    run_op(8'h0F, 8'h44, 8'h46, 5'b00000, 1'b1, 1'b0, 32'h0, 32'h0, 32'hCAFE_F00D, 0, 3, "R5");
    run_op(8'h0F, 8'h45, 8'h9E, 5'b00000, 1'b0, 1'b0, 32'h7777_8888, 32'h0, 32'h1111_2222, 0, 2, "R7");
    // R6: fault with true and false condition
    run_op(8'h0F, 8'h42, 8'h0D, 5'b00001, 1'b1, 1'b0, 32'h0, 32'h0, 32'h5, 1, 1, "R6");
    run_op(8'h0F, 8'h43, 8'h0D, 5'b00001, 1'b1, 1'b0, 32'h0, 32'h0, 32'h5, 1, 4, "R6");
    // R1: neighbouring opcodes do nothing, even with a memory ModR/M
    run_op(8'h0F, 8'h50, 8'h06, 5'b00000, 1'b1, 1'b0, 32'h0, 32'h9, 32'h0, 0, 0, "R1");
    run_op(8'h0E, 8'h41, 8'hC1, 5'b00000, 1'b1, 1'b0, 32'h0, 32'h9, 32'h0, 0, 0, "R1");
    run_op(8'h8B, 8'h4F, 8'h00, 5'b00000, 1'b1, 1'b0, 32'h0, 32'h9, 32'h0, 0, 0, "R1");
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R8", "all done pulses seen", q.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule